// File: doc/BRIEF.md
# Exception Stacking Sequencer with Alignment Checking

When an exception is accepted, this block saves the processor context on a stack that grows downward. It first writes the status word and then the program counter. Each save is one word write on a simple bus port with a ready handshake. Before each save the working stack pointer drops by one word. At the end the block presents the updated stack pointer for one cycle so the core can load it back.

The block also checks alignment. It tests the incoming stack pointer and the vector base value for word alignment. A misaligned value does not stop the stacking. Both writes still go out, each at the working pointer with its low address bits forced to zero. The fault is recorded in a pending flag, and the surrounding logic starts the address-error exception once the current stacking has finished. A request tagged as the address-error exception clears that flag when it is accepted, and it records no new fault even if the pointer is still misaligned. The error therefore cannot re-enter itself, and control always reaches its handler.

Top module: `exc_stack_seq`

## Requirements
- R1: While reset is held and right after it, `busy`, `bus_we`, `sp_out_valid` and `ae_pending` are all 0.
- R2: A request seen while the block is idle is accepted at that clock edge. `busy` is 1 from the next cycle through the final (done) cycle. Requests that arrive while `busy` is 1 are ignored.
- R3: Stacking makes exactly two writes, the status word first and the program counter second. The first goes to SP-4 and the second to SP-8, each with the low two bits cleared. A write holds its address and data steady until `bus_rdy` is seen high at a clock edge.
- R4: When SP is misaligned, both writes are still issued. Each write address has bits [1:0] equal to 0.
- R5: A request without the address-error tag, accepted with SP bits [1:0] not equal to 0, sets `ae_pending` in the cycle after acceptance. The flag stays set while stacking completes.
- R6: A request without the address-error tag, accepted with vector base bits [1:0] not equal to 0, also sets `ae_pending`.
- R7: A request with the address-error tag (`req_is_ae`=1) clears `ae_pending` in the cycle after acceptance. It sets no new fault, even when SP or the vector base is misaligned.
- R8: In the cycle after the second write completes, `sp_out_valid` is 1 for exactly one cycle and `sp_out` equals the accepted SP minus 8. Any misalignment is kept in that value.
- R9: When SP is aligned, `bus_wdata` carries the accepted status word during the first write and the accepted program counter during the second. Data is not specified for misaligned writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Exception accepted, start stacking |
| req_is_ae | input | 1 | Tag: the request is the address-error exception |
| sp_in | input | AW | Current stack pointer |
| vbr_in | input | AW | Current vector base value |
| sr_in | input | DW | Status word to save |
| pc_in | input | DW | Program counter to save |
| busy | output | 1 | Stacking in progress |
| bus_addr | output | AW | Write address (word aligned) |
| bus_wdata | output | DW | Write data |
| bus_we | output | 1 | Write strobe |
| bus_rdy | input | 1 | Bus accepts the current write |
| sp_out | output | AW | Stack pointer after stacking |
| sp_out_valid | output | 1 | One-cycle strobe for `sp_out` |
| ae_pending | output | 1 | Address error queued |

## Verification
The bench targets misaligned pointers, where two failure modes are possible. A design that failed to mask the low bits would put unaligned addresses on the bus. A design that realigned the pointer itself would return SP minus 8 rounded down instead of keeping the misalignment. The bench stalls the bus ready line so that a design advancing without the handshake shows up as skipped or shortened writes. It sends requests while the block is busy to catch a design that restarts mid-sequence. It sends an address-error-tagged request with a misaligned pointer: a design that re-flagged it would leave `ae_pending` set and loop forever. A misaligned vector base alone is also tested, to catch a check that looks only at the stack pointer.

// File: rtl/exc_stack_pkg.sv
// Shared types for the exception stacking sequencer.
// Assumes a word size that is a power of two in bytes.
package exc_stack_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_PUSH_SR = 2'd1,
        ST_PUSH_PC = 2'd2,
        ST_DONE    = 2'd3
    } stk_state_t;

endpackage

// File: rtl/exc_align_chk.sv
// Alignment checker: flags a stack pointer or vector base whose low
// address bits are not zero. Purely combinational; assumes LSB >= 1.
module exc_align_chk #(
    parameter int AW  = 32,
    parameter int LSB = 2
) (
    input  logic [AW-1:0] sp,
    input  logic [AW-1:0] vbr,
    output logic          misaligned
);

    // Any set bit below the word boundary is an alignment fault.
    always_comb begin
        misaligned = (|sp[LSB-1:0]) | (|vbr[LSB-1:0]);
    end

endmodule

// File: rtl/exc_ae_track.sv
// Address-error tracker: holds a one-bit queued fault. Assumes `accept`
// pulses for one cycle when the sequencer takes a request.
module exc_ae_track (
    input  logic clk,
    input  logic rst_n,
    input  logic accept,
    input  logic accept_is_ae,
    input  logic misaligned,
    output logic pending
);

    // Clear on the address-error exception's own stacking; set on faults of others.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending <= 1'b0;
        end else if (accept) begin
            if (accept_is_ae) begin
                pending <= 1'b0;
            end else if (misaligned) begin
                pending <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/exc_push_fsm.sv
// Push sequencer: on acceptance, latches SP, SR and PC, then writes SR
// and PC at successively lower word-aligned addresses, each waiting for
// bus ready, and finally strobes the decremented SP for one cycle.
// Assumes the bus holds no state between writes.
module exc_push_fsm
    import exc_stack_pkg::*;
#(
    parameter int AW         = 32,
    parameter int DW         = 32,
    parameter int WORD_BYTES = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [AW-1:0] sp_in,
    input  logic [DW-1:0] sr_in,
    input  logic [DW-1:0] pc_in,
    input  logic          bus_rdy,
    output logic          accept,
    output logic          busy,
    output logic [AW-1:0] bus_addr,
    output logic [DW-1:0] bus_wdata,
    output logic          bus_we,
    output logic [AW-1:0] sp_out,
    output logic          sp_out_valid
);

    localparam int LSB = $clog2(WORD_BYTES);

    stk_state_t    state_q;
    logic [AW-1:0] sp_q;
    logic [DW-1:0] sr_q;
    logic [DW-1:0] pc_q;
    logic [AW-1:0] sp_dec;

    // Next pointer value and the request handshake.
    always_comb begin
        sp_dec = sp_q - AW'(WORD_BYTES);
        accept = req_valid && (state_q == ST_IDLE);
    end

    // Sequencer state and the working copies of the context.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            sp_q    <= '0;
            sr_q    <= '0;
            pc_q    <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        sp_q    <= sp_in;
                        sr_q    <= sr_in;
                        pc_q    <= pc_in;
                        state_q <= ST_PUSH_SR;
                    end
                end
                ST_PUSH_SR: begin
                    if (bus_rdy) begin
                        sp_q    <= sp_dec;
                        state_q <= ST_PUSH_PC;
                    end
                end
                ST_PUSH_PC: begin
                    if (bus_rdy) begin
                        sp_q    <= sp_dec;
                        state_q <= ST_DONE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Bus write port and result strobe, decoded from the state.
    always_comb begin
        busy         = (state_q != ST_IDLE);
        bus_we       = (state_q == ST_PUSH_SR) || (state_q == ST_PUSH_PC);
        bus_addr     = {sp_dec[AW-1:LSB], {LSB{1'b0}}};
        bus_wdata    = (state_q == ST_PUSH_PC) ? pc_q : sr_q;
        sp_out       = sp_q;
        sp_out_valid = (state_q == ST_DONE);
    end

endmodule

// File: rtl/exc_stack_seq.sv
// Exception stacking sequencer top: joins the push sequencer, the
// alignment checker and the queued address-error tracker. Assumes the
// outer logic starts the address-error exception when busy is low and
// ae_pending is high.
module exc_stack_seq #(
    parameter int AW         = 32,
    parameter int DW         = 32,
    parameter int WORD_BYTES = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          req_is_ae,
    input  logic [AW-1:0] sp_in,
    input  logic [AW-1:0] vbr_in,
    input  logic [DW-1:0] sr_in,
    input  logic [DW-1:0] pc_in,
    output logic          busy,
    output logic [AW-1:0] bus_addr,
    output logic [DW-1:0] bus_wdata,
    output logic          bus_we,
    input  logic          bus_rdy,
    output logic [AW-1:0] sp_out,
    output logic          sp_out_valid,
    output logic          ae_pending
);

    localparam int LSB = $clog2(WORD_BYTES);

    logic accept;
    logic misaligned;

    exc_push_fsm #(.AW(AW), .DW(DW), .WORD_BYTES(WORD_BYTES)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .sp_in        (sp_in),
        .sr_in        (sr_in),
        .pc_in        (pc_in),
        .bus_rdy      (bus_rdy),
        .accept       (accept),
        .busy         (busy),
        .bus_addr     (bus_addr),
        .bus_wdata    (bus_wdata),
        .bus_we       (bus_we),
        .sp_out       (sp_out),
        .sp_out_valid (sp_out_valid)
    );

    exc_align_chk #(.AW(AW), .LSB(LSB)) u_align (
        .sp         (sp_in),
        .vbr        (vbr_in),
        .misaligned (misaligned)
    );

    exc_ae_track u_track (
        .clk          (clk),
        .rst_n        (rst_n),
        .accept       (accept),
        .accept_is_ae (req_is_ae),
        .misaligned   (misaligned),
        .pending      (ae_pending)
    );

endmodule

// File: rtl/exc_stack_seq_chk.sv
// Checker for the exception stacking sequencer, bound to the top.
module exc_stack_seq_chk #(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic          req_is_ae,
    input logic [AW-1:0] sp_in,
    input logic          busy,
    input logic [AW-1:0] bus_addr,
    input logic [DW-1:0] bus_wdata,
    input logic          bus_we,
    input logic          bus_rdy,
    input logic          sp_out_valid,
    input logic          ae_pending
);

    AST_ACCEPT_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy) |=> (busy && bus_we)); // R2
    AST_WRITE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && !bus_rdy) |=> (bus_we && $stable(bus_addr) && $stable(bus_wdata))); // R3
    AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        bus_we |-> (bus_addr[1:0] == 2'b00)); // R4
    AST_PEND_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy && !req_is_ae && (sp_in[1:0] != 2'b00)) |=> ae_pending); // R5
    AST_AE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy && req_is_ae) |=> !ae_pending); // R7
    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        sp_out_valid |=> (!sp_out_valid && !busy)); // R8

endmodule

bind exc_stack_seq exc_stack_seq_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_is_ae    (req_is_ae),
    .sp_in        (sp_in),
    .busy         (busy),
    .bus_addr     (bus_addr),
    .bus_wdata    (bus_wdata),
    .bus_we       (bus_we),
    .bus_rdy      (bus_rdy),
    .sp_out_valid (sp_out_valid),
    .ae_pending   (ae_pending)
);

// File: tb/exc_stack_seq_tb.sv
// Bench: behavioural reference model updated at each rising edge from the
// driven inputs, compared with the outputs at every falling edge.
module exc_stack_seq_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_is_ae = 1'b0;
    logic [31:0] sp_in = '0;
    logic [31:0] vbr_in = '0;
    logic [31:0] sr_in = '0;
    logic [31:0] pc_in = '0;
    logic        bus_rdy = 1'b1;
    logic        busy;
    logic [31:0] bus_addr;
    logic [31:0] bus_wdata;
    logic        bus_we;
    logic [31:0] sp_out;
    logic        sp_out_valid;
    logic        ae_pending;

    int errors = 0;
    int checks = 0;
    int stall_mode = 0;
    int rdy_cnt = 0;
    int writes_seen = 0;
    bit done = 0;

    // reference model state
    int          m_phase = 0;
    logic [31:0] m_sp = '0;
    logic [31:0] m_sr = '0;
    logic [31:0] m_pc = '0;
    bit          m_pend = 0;

    exc_stack_seq u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_is_ae(req_is_ae),
        .sp_in(sp_in), .vbr_in(vbr_in), .sr_in(sr_in), .pc_in(pc_in),
        .busy(busy), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_we(bus_we),
        .bus_rdy(bus_rdy), .sp_out(sp_out), .sp_out_valid(sp_out_valid),
        .ae_pending(ae_pending)
    );

    always #4 clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // ready pattern: always ready, or ready one cycle in three
    always @(posedge clk) begin
        #2;
        rdy_cnt++;
        bus_rdy = (stall_mode == 0) || (rdy_cnt % 3 == 0);
    end

    // reference model
    always @(posedge clk) begin
        if (!rst_n) begin
            m_phase = 0; m_sp = '0; m_pend = 0;
        end else begin
            case (m_phase)
                0: if (req_valid) begin
                    m_sp = sp_in; m_sr = sr_in; m_pc = pc_in;
                    if (req_is_ae) m_pend = 0;
                    else if (sp_in[1:0] != 0 || vbr_in[1:0] != 0) m_pend = 1;
                    m_phase = 1;
                end
                1, 2: if (bus_rdy) begin
                    m_sp = m_sp - 32'd4;
                    m_phase = m_phase + 1;
                end
                default: m_phase = 0;
            endcase
        end
    end

    // cycle compare
    always @(negedge clk) begin
        if (rst_n && !done) begin
            logic [31:0] ea;
            ea = (m_sp - 32'd4) & 32'hFFFF_FFFC;
            check("R2 busy", {31'd0, busy}, {31'd0, m_phase != 0});
            check("R3 bus_we", {31'd0, bus_we}, {31'd0, (m_phase == 1 || m_phase == 2)});
            if (m_phase == 1 || m_phase == 2) begin
                check("R3/R4 bus_addr", bus_addr, ea);
                if (m_sp[1:0] == 2'b00)
                    check("R9 bus_wdata", bus_wdata, (m_phase == 1) ? m_sr : m_pc);
                if (bus_rdy) writes_seen++;
            end
            check("R8 sp_out_valid", {31'd0, sp_out_valid}, {31'd0, m_phase == 3});
            if (m_phase == 3) check("R8 sp_out", sp_out, m_sp);
            check("R5/R6/R7 ae_pending", {31'd0, ae_pending}, {31'd0, m_pend});
        end
    end

    task automatic run_req(input logic [31:0] sp, input logic [31:0] vbr,
                           input logic [31:0] sr, input logic [31:0] pc,
                           input bit is_ae, input bit poke_busy);
        @(posedge clk); #1;
        sp_in = sp; vbr_in = vbr; sr_in = sr; pc_in = pc; req_is_ae = is_ae;
        req_valid = 1'b1;
        @(posedge clk); #1;
        req_valid = 1'b0;
        if (poke_busy) begin
            // R2: a request while busy must be ignored
            sp_in = 32'h0000_5550; sr_in = 32'hDEAD_0000; req_is_ae = 1'b1;
            req_valid = 1'b1;
            @(posedge clk); #1;
            req_valid = 1'b0;
        end
        for (int i = 0; i < 40; i++) begin
            @(posedge clk); #1;
            if (!busy) break;
        end
        check("R2 idle after sequence", {31'd0, busy}, 32'd0);
    endtask

    initial begin
        #(8 * 200000);
        errors++; checks++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: outputs quiet during reset
        check("R1 busy", {31'd0, busy}, 32'd0);
        check("R1 bus_we", {31'd0, bus_we}, 32'd0);
        check("R1 sp_out_valid", {31'd0, sp_out_valid}, 32'd0);
        check("R1 ae_pending", {31'd0, ae_pending}, 32'd0);
        @(posedge clk); #1 rst_n = 1'b1;

        // aligned, no stalls
        writes_seen = 0;
        run_req(32'h0000_2000, 32'h0, 32'h1111_00F0, 32'h0000_0404, 0, 0);
        check("R3 two writes", writes_seen, 2);
        check("R8 final sp", sp_out, 32'h0000_1FF8);
        // aligned, stalled bus, busy poke
        stall_mode = 1;
        writes_seen = 0;
        run_req(32'h0000_3000, 32'h0, 32'hAAAA_5555, 32'h1234_5678, 0, 1);
        check("R2 busy request ignored, two writes", writes_seen, 2);
        check("R2 busy request ignored, sp kept", sp_out, 32'h0000_2FF8);
        check("R5 no pending when aligned", {31'd0, ae_pending}, 32'd0);
        // misaligned SP
        writes_seen = 0;
        run_req(32'h0000_4002, 32'h0, 32'h0000_0001, 32'h0000_0002, 0, 0);
        check("R4 misaligned still two writes", writes_seen, 2);
        check("R8 misalignment kept", sp_out, 32'h0000_3FFA);
        check("R5 pending after misaligned sp", {31'd0, ae_pending}, 32'd1);
        // address-error stacking with the same misaligned SP
        stall_mode = 0;
        run_req(32'h0000_3FFA, 32'h0, 32'h0000_0003, 32'h0000_0004, 1, 0);
        check("R7 pending cleared, no re-flag", {31'd0, ae_pending}, 32'd0);
        // misaligned vector base only
        run_req(32'h0000_6000, 32'h0000_0101, 32'h0000_0005, 32'h0000_0006, 0, 0);
        check("R6 pending after misaligned vbr", {31'd0, ae_pending}, 32'd1);
        // address-error stacking with misaligned vbr
        stall_mode = 1;
        run_req(32'h0000_5FF8, 32'h0000_0101, 32'h0000_0007, 32'h0000_0008, 1, 1);
        check("R7 vbr fault ignored for address-error", {31'd0, ae_pending}, 32'd0);
        // reset mid-sequence
        @(posedge clk); #1;
        sp_in = 32'h0000_7001; req_is_ae = 0; req_valid = 1'b1;
        @(posedge clk); #1 req_valid = 1'b0; rst_n = 1'b0;
        @(posedge clk); #1;
        check("R1 busy after reset", {31'd0, busy}, 32'd0);
        check("R1 pending after reset", {31'd0, ae_pending}, 32'd0);
        rst_n = 1'b1;
        repeat (3) @(posedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule